// File: doc/BRIEF.md
# Timestamped Output Port Bank

The block is a bank of output ports that share one 16-bit tick counter. A requester does not write a pin value straight to a port. It queues a pair made of a target count and a data pattern. The port holds that pattern back until the shared counter reaches the target, then drives it on its pins. All ports read the same counter, so edges requested for the same count on different ports appear on the same clock edge. Edges requested for adjacent counts appear exactly one tick apart. With a 25 MHz tick strobe, one tick is 40 ns.

Each port keeps a small FIFO of pending timed writes, so one requester can schedule several future edges ahead of time. Only the oldest pending entry is compared with the counter. Later entries must carry later counts. The port width (1, 8 or 16 bits) is chosen per port, and a wide port drives its whole pattern at once. A global enable starts and stops the timebase. While the enable is low the counter rests at zero.

Top module: `timed_port_bank`

## Requirements
- R1: After reset, `now_count` is 0, every pin is 0, and every `req_ready` bit is 1.
- R2: While `enable` is low, `now_count` is held at 0, and it returns to 0 on the first clock after `enable` falls. While `enable` is high, `now_count` advances by one on each clock edge where `tick` is high and holds otherwise.
- R3: The counter wraps from 65535 to 0. An entry whose count is 0 fires at that wrap. Raising `enable` does not fire it, because the counter starts at 0 without stepping into 0.
- R4: A port accepts a request on a clock edge where both its `req_valid` bit and its `req_ready` bit are high. `req_ready` is low exactly while the port holds DEPTH (default 4) pending entries. A request offered while `req_ready` is low is dropped.
- R5: If a port's oldest pending entry has count T, its pins take that entry's data on the clock edge where `now_count` changes from T-1 to T. The entry then leaves the FIFO. The new pin value and `now_count` = T become visible together.
- R6: Only the oldest pending entry is compared with the counter. A younger entry whose count is reached first does not fire and waits behind the head, which may wait a full counter wrap.
- R7: Pins hold their value between firings. While `enable` is low, no entry fires and the pins do not change.
- R8: Port p drives its data on the low PORT_W[p] bits of its 16-bit lane `pins[16p+15:16p]`, and the remaining bits of that lane are always 0. The default widths are 1, 8, 16 and 16 for ports 0 to 3.
- R9: Entries on different ports with the same count change their pins on the same clock edge. Entries with counts one apart change their pins exactly one tick apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global enable; low holds the counter at 0 and freezes firing |
| tick | input | 1 | Counter step strobe, one clock wide per tick |
| req_valid | input | NPORTS | Per-port request valid |
| req_ready | output | NPORTS | Per-port FIFO has room |
| req_count | input | NPORTS*16 | Per-port target count, port p at bits [16p+15:16p] |
| req_data | input | NPORTS*16 | Per-port data pattern, port p at bits [16p+15:16p] |
| pins | output | NPORTS*16 | Per-port output lanes, port p at bits [16p+15:16p] |
| now_count | output | 16 | Current shared counter value |

## Verification
A FIFO pointer or occupancy error shows up at the ports in one of three ways: the wrong pattern on a lane, a `req_ready` that stays low or high when it should not, or an entry firing out of order. Each of these is visible at the tick where the affected entry should have fired. An error in the compare or in the counter moves an edge by at least one tick, or by a full 65536-tick wrap. It can therefore be seen on the first scheduled event after the fault. The stimulus schedules a dense stream of near-future events, so most internal faults reach the pins within a few ticks.

// File: rtl/timed_port_bank.sv
module timed_port_bank #(
  parameter int NPORTS = 4,
  parameter int CW     = 16,
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int PORT_W [NPORTS] = '{1, 8, 16, 16}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 tick,
  input  logic [NPORTS-1:0]    req_valid,
  output logic [NPORTS-1:0]    req_ready,
  input  logic [NPORTS*CW-1:0] req_count,
  input  logic [NPORTS*DW-1:0] req_data,
  output logic [NPORTS*DW-1:0] pins,
  output logic [CW-1:0]        now_count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          step;
  logic [CW-1:0] cnt_nxt;

  assign step    = enable & tick;
  assign cnt_nxt = now_count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       now_count <= '0;
    else if (!enable) now_count <= '0;
    else if (tick)    now_count <= cnt_nxt;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    localparam int PW = PORT_W[g];
    localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - PW);

    logic [CW-1:0] q_cnt [DEPTH];
    logic [DW-1:0] q_dat [DEPTH];
    logic [AW-1:0] rd, wr;
    logic [AW:0]   used;
    logic [DW-1:0] lane;
    logic          push, hit;

    assign req_ready[g] = (used != FULL);
    assign push = req_valid[g] & req_ready[g];
    assign hit  = (used != '0) & step & (q_cnt[rd] == cnt_nxt);
    assign pins[g*DW +: DW] = lane;

    always_ff @(posedge clk)
      if (push) begin
        q_cnt[wr] <= req_count[g*CW +: CW];
        q_dat[wr] <= req_data[g*DW +: DW] & MASK;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rd   <= '0;
        wr   <= '0;
        used <= '0;
        lane <= '0;
      end else begin
        if (push) wr <= (wr == LAST) ? '0 : wr + 1'b1;
        if (hit) begin
          rd   <= (rd == LAST) ? '0 : rd + 1'b1;
          lane <= q_dat[rd];
        end
        case ({push, hit})
          2'b10:   used <= used + 1'b1;
          2'b01:   used <= used - 1'b1;
          default: used <= used;
        endcase
      end
  end
endmodule

// File: rtl/timed_port_bank_chk.sv
module timed_port_bank_chk #(
  parameter int NPORTS = 4,
  parameter int CW     = 16,
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int PORT_W [NPORTS] = '{1, 8, 16, 16}
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 tick,
  input logic [NPORTS-1:0]    req_valid,
  input logic [NPORTS-1:0]    req_ready,
  input logic [NPORTS*CW-1:0] req_count,
  input logic [NPORTS*DW-1:0] req_data,
  input logic [NPORTS*DW-1:0] pins,
  input logic [CW-1:0]        now_count
);
  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> now_count == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && tick |=> now_count == CW'($past(now_count) + 1'b1));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !tick |=> $stable(now_count));

  p_pins_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && tick) |=> $stable(pins));

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - PORT_W[g]);

    p_lane_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pins[g*DW +: DW] & ~MASK) == '0);

    p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready[g] && !(enable && tick) |=> !req_ready[g]);
  end
endmodule

bind timed_port_bank timed_port_bank_chk #(
  .NPORTS(NPORTS), .CW(CW), .DW(DW), .DEPTH(DEPTH), .PORT_W(PORT_W)
) u_chk (.*);

// File: tb/test_timed_port_bank.sv
`timescale 1ns/1ps
module test_timed_port_bank;
  localparam int NP = 4;
  int BW [NP] = '{1, 8, 16, 16};

  logic            clk = 0, rst_n = 0, enable = 0, tick = 0;
  logic [NP-1:0]   req_valid = '0;
  logic [NP-1:0]   req_ready;
  logic [NP*16-1:0] req_count = '0, req_data = '0;
  logic [NP*16-1:0] pins;
  logic [15:0]     now_count;

  timed_port_bank i_timed_port_bank (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_count(req_count), .req_data(req_data),
    .pins(pins), .now_count(now_count));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [15:0] mask(int p);
    return 16'hFFFF >> (16 - BW[p]);
  endfunction

  function automatic logic [15:0] lane(int p);
    return pins[p*16 +: 16];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] mq [NP][$];
  logic [15:0] m_cnt;
  logic [15:0] m_pins [NP];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_cnt = '0;
      for (int p = 0; p < NP; p++) begin
        mq[p].delete();
        m_pins[p] = '0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        int sz;
        sz = mq[p].size();
        if (enable && tick && sz > 0 && mq[p][0][31:16] == 16'(m_cnt + 16'd1)) begin
          m_pins[p] = mq[p][0][15:0] & mask(p);
          void'(mq[p].pop_front());
        end
        if (req_valid[p] && sz < 4)
          mq[p].push_back({req_count[p*16 +: 16], req_data[p*16 +: 16]});
      end
      if (!enable) m_cnt = '0;
      else if (tick) m_cnt = m_cnt + 16'd1;
    end

  always @(negedge clk)
    if (rst_n && !done) begin
      chk(now_count, m_cnt, "R2 scoreboard count");
      for (int p = 0; p < NP; p++) begin
        chk(lane(p), m_pins[p], "R5 scoreboard pins");
        chk(req_ready[p], mq[p].size() < 4, "R4 scoreboard ready");
      end
    end

  task automatic tick_once();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic put(input int p, input logic [15:0] c, input logic [15:0] d);
    req_valid[p] = 1;
    req_count[p*16 +: 16] = c;
    req_data[p*16 +: 16] = d;
  endtask

  task automatic push1(input int p, input logic [15:0] c, input logic [15:0] d);
    @(negedge clk) put(p, c, d);
    @(negedge clk) req_valid = '0;
  endtask

  function automatic bit all_empty();
    for (int p = 0; p < NP; p++) if (mq[p].size() != 0) return 0;
    return 1;
  endfunction

  initial begin
    logic [15:0] c;
    logic [15:0] last [NP];
    void'($urandom(32'd20151124));
    repeat (3) @(negedge clk);
    chk(now_count, 16'h0, "R1 reset count");
    chk(pins, '0, "R1 reset pins");
    chk(req_ready, 4'hF, "R1 reset ready");
    rst_n = 1;

    repeat (3) tick_once();
    chk(now_count, 16'h0, "R2 count held while disabled");

    @(negedge clk) enable = 1;
    for (int i = 0; i < 5; i++) begin
      repeat (7) @(negedge clk);
      tick_once();
    end
    chk(now_count, 16'd5, "R2 count after five ticks");
    repeat (4) @(negedge clk);
    chk(now_count, 16'd5, "R2 count holds without tick");

    c = now_count;
    @(negedge clk) begin put(0, c + 16'd1, 16'hFFFF); put(1, c + 16'd1, 16'hABCD); end
    @(negedge clk) req_valid = '0;
    tick_once();
    chk(lane(0), 16'h0001, "R8 one-bit lane");
    chk(lane(1), 16'h00CD, "R8 eight-bit lane");

    c = now_count;
    @(negedge clk) begin
      put(0, c + 16'd3, 16'h0000); put(1, c + 16'd3, 16'h0042); put(2, c + 16'd4, 16'h7E81);
    end
    @(negedge clk) req_valid = '0;
    tick_once(); tick_once();
    chk(lane(1), 16'h00CD, "R5 no fire before target");
    tick_once();
    chk(now_count, c + 16'd3, "R5 count at target");
    chk(lane(0), 16'h0000, "R9 port0 same edge");
    chk(lane(1), 16'h0042, "R9 port1 same edge");
    chk(lane(2), 16'h0000, "R9 port2 not yet");
    tick_once();
    chk(lane(2), 16'h7E81, "R9 port2 one tick later");

    c = now_count;
    push1(1, c + 16'd6, 16'h0011);
    push1(1, c + 16'd3, 16'h0022);
    repeat (4) tick_once();
    chk(lane(1), 16'h0042, "R6 younger entry blocked");
    repeat (2) tick_once();
    chk(lane(1), 16'h0011, "R6 head fires in order");

    c = now_count;
    for (int k = 0; k < 4; k++) push1(3, c + 16'd100 + 16'(k), 16'hA000 + 16'(k));
    chk(req_ready[3], 1'b0, "R4 ready low when full");
    push1(3, c + 16'd104, 16'hDEAD);
    repeat (101) tick_once();
    chk(req_ready[3], 1'b1, "R4 ready back after pop");
    repeat (4) tick_once();
    chk(lane(3), 16'hA003, "R4 dropped request never fires");

    @(negedge clk) enable = 0;
    push1(3, 16'd1, 16'h1234);
    repeat (3) tick_once();
    chk(now_count, 16'h0, "R2 count zero after enable fall");
    chk(lane(3), 16'hA003, "R7 pins hold while disabled");
    @(negedge clk) enable = 1;
    @(negedge clk);
    chk(lane(3), 16'hA003, "R7 pins hold without tick");
    tick_once();
    chk(lane(3), 16'h1234, "R5 fire at count one after enable");

    for (int p = 0; p < NP; p++) last[p] = now_count;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      tick = ($urandom % 4) == 0;
      enable = ($urandom % 64) != 0;
      for (int p = 0; p < NP; p++) begin
        if (($urandom % 3) == 0 && mq[p].size() < 4) begin
          logic [15:0] cand, ahead;
          cand = last[p] + 16'd1 + 16'($urandom % 4);
          ahead = cand - m_cnt;
          if (ahead < 16'd2 || ahead > 16'h8000) cand = m_cnt + 16'd2 + 16'($urandom % 4);
          last[p] = cand;
          put(p, cand, 16'($urandom));
        end else req_valid[p] = 0;
      end
    end
    @(negedge clk) begin req_valid = '0; enable = 1; tick = 1; end
    for (int i = 0; i < 70000 && !all_empty(); i++) @(negedge clk);
    tick = 0;
    chk(all_empty(), 1'b1, "R6 all queues drain");

    push1(2, 16'h0000, 16'h5A5A);
    push1(0, 16'hFFFF, 16'h0001);
    @(negedge clk) tick = 1;
    while (m_cnt != 16'hFFFE) @(negedge clk);
    tick = 0;
    @(negedge clk);
    chk(lane(2) == 16'h5A5A, 1'b0, "R3 zero entry not fired early");
    tick_once();
    chk(now_count, 16'hFFFF, "R3 count at top");
    chk(lane(0), 16'h0001, "R3 fire at 65535");
    tick_once();
    chk(now_count, 16'h0000, "R3 wrap to zero");
    chk(lane(2), 16'h5A5A, "R3 zero entry fires at wrap");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 195000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule